// File: doc/BRIEF.md
# NAND Flash Register-Mapped Bus Adapter

The adapter connects a simple synchronous host memory bus to a bank of up to sixteen raw 8-bit NAND flash dies. The dies share one 8-bit I/O bus and one set of control strobes: command latch enable, address latch enable, read enable (active low) and write enable (active low). Each die has its own active-low chip enable and its own ready/busy line. Host software builds every NAND operation (command, address, data in, data out) out of single accesses to fixed offsets. One register picks the die. A status register shows all ready/busy lines at once.

Each command, address or data access becomes exactly one NAND bus cycle. The adapter holds the host access with an acknowledge until that cycle is complete. The widths of the low and high phases of the strobes are parameters counted in system clocks. The adapter always allows at least one clock of setup before a write strobe falls and at least one clock of hold after it rises. Error correction, page buffering and command ordering are left to software.

Top module: `nand_bus_bridge`

## Requirements
- R1: Writing word V to offset 0x0FFFFFFC sets the die select. If V < 16, only `nf_ce_n[V]` is low. Any V of 16 or more, and the reset state, leave all sixteen enables high. Writes to other offsets leave the enables unchanged.
- R2: A read at offset 0x0FFFFFF8 returns the ready/busy inputs after a two-flop synchronizer. Bit i holds die i, where 1 means ready and 0 means busy. Bits 31..16 read as zero.
- R3: A write to offset 0x00 produces one data-input cycle. CLE and ALE stay low. One write-enable pulse, T_LOW clocks long, carries `host_wdata[7:0]` on `nf_io_out` with `nf_io_oe` high.
- R4: A write to offset 0x01 produces a command cycle. CLE is high and ALE is low for the whole write-enable pulse, and the byte is `host_wdata[7:0]`.
- R5: A write to offset 0x02 produces an address cycle. ALE is high and CLE is low for the whole write-enable pulse.
- R6: A read at offset 0x00 produces one read-enable pulse, T_LOW clocks long, with CLE and ALE low. `nf_io_in` is captured in the last low clock. It is returned in `host_rdata[7:0]`, with the upper bits zero.
- R7: For write cycles, CLE, ALE, data and output enable are settled at least one clock before the write enable falls. They are held unchanged for T_HIGH (at least 1) clocks after it rises.
- R8: `host_ack` is a one-clock pulse. After a NAND cycle it arrives 2+T_LOW+T_HIGH clock edges after the request is first seen. After a register access or an unmapped offset it arrives on the next edge. Unmapped offsets produce no strobe, and unmapped reads return zero.
- R9: `nf_io_oe` is low except during the setup, strobe and hold clocks of a write cycle. It is never high while read enable is low.
- R10: The write-enable and read-enable strobes are never low at the same time. Each NAND cycle produces exactly one strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access request, held until ack |
| host_wr | input | 1 | Access is a write |
| host_rd | input | 1 | Access is a read |
| host_addr | input | ADDR_W | Byte offset within the adapter window |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid with ack and held afterwards |
| host_ack | output | 1 | One-clock access completion pulse |
| nf_cle | output | 1 | Shared command latch enable |
| nf_ale | output | 1 | Shared address latch enable |
| nf_we_n | output | 1 | Shared write enable, active low |
| nf_re_n | output | 1 | Shared read enable, active low |
| nf_ce_n | output | NUM_DIE | Per-die chip enable, active low |
| nf_io_out | output | 8 | I/O bus value driven during writes |
| nf_io_oe | output | 1 | I/O bus output enable |
| nf_io_in | input | 8 | I/O bus value from the dies |
| nf_rb | input | NUM_DIE | Per-die ready/busy, 1 = ready |

## Verification
Two functions can act in the same clock. One is the data capture at the end of a read-enable pulse. The other is a ready/busy line changing as it enters the synchronizer. The bench changes the ready/busy inputs while a data-output cycle is running. It then expects the captured byte to match the bus model exactly, and a status read after the acknowledge to show the new ready/busy pattern. A scoreboard queue holds the expected strobe events. Each observed pulse is checked against it for kind, byte, length, setup and exclusivity. A strobe that nobody asked for, such as one from an unmapped offset, shows up as an event with no queued entry.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  localparam logic [31:0] OFS_DIESEL = 32'h0FFF_FFFC;
  localparam logic [31:0] OFS_STATUS = 32'h0FFF_FFF8;
  localparam logic [31:0] OFS_DATA   = 32'h0000_0000;
  localparam logic [31:0] OFS_CMD    = 32'h0000_0001;
  localparam logic [31:0] OFS_ADR    = 32'h0000_0002;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_DIESEL, ACC_STATUS, ACC_DWR, ACC_CMD, ACC_ADR, ACC_DRD
  } acc_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_LOW, SQ_HIGH} seq_e;

  function automatic acc_e classify(input logic [31:0] a, input logic wr, input logic rd);
    acc_e k;
    k = ACC_NONE;
    if (wr) begin
      if (a == OFS_DIESEL)    k = ACC_DIESEL;
      else if (a == OFS_DATA) k = ACC_DWR;
      else if (a == OFS_CMD)  k = ACC_CMD;
      else if (a == OFS_ADR)  k = ACC_ADR;
    end else if (rd) begin
      if (a == OFS_STATUS)    k = ACC_STATUS;
      else if (a == OFS_DATA) k = ACC_DRD;
    end
    return k;
  endfunction

  function automatic logic is_nand(input acc_e k);
    return (k == ACC_DWR) || (k == ACC_CMD) || (k == ACC_ADR) || (k == ACC_DRD);
  endfunction

  function automatic logic is_wcycle(input acc_e k);
    return (k == ACC_DWR) || (k == ACC_CMD) || (k == ACC_ADR);
  endfunction

  function automatic int larger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nbb_rb_sync.sv
module nbb_rb_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/nbb_ce_decode.sv
module nbb_ce_decode #(
  parameter int NUM_DIE = 16,
  parameter int DATA_W  = 32
) (
  input  logic [DATA_W-1:0]  sel_word,
  output logic [NUM_DIE-1:0] ce_n
);
  for (genvar g = 0; g < NUM_DIE; g++) begin : g_ce
    assign ce_n[g] = (sel_word != DATA_W'(g));
  end
endmodule

// File: rtl/nbb_strobe_seq.sv
module nbb_strobe_seq
  import nbb_pkg::*;
#(
  parameter int T_LOW  = 3,
  parameter int T_HIGH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  acc_e       kind_in,
  input  logic [7:0] dbyte_in,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic       oe,
  output logic [7:0] io_out,
  output logic       cap_en,
  output logic       done
);
  localparam int CNT_W = $clog2(larger(T_LOW, T_HIGH) + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(T_LOW - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(T_HIGH - 1);

  seq_e             st;
  logic [CNT_W-1:0] cnt;
  acc_e             kind;
  logic [7:0]       dbyte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      kind    <= ACC_NONE;
      dbyte_q <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st      <= SQ_SETUP;
          kind    <= kind_in;
          dbyte_q <= dbyte_in;
        end
        SQ_SETUP: begin
          st  <= SQ_LOW;
          cnt <= LOW_LAST;
        end
        SQ_LOW: if (cnt == '0) begin
          st  <= SQ_HIGH;
          cnt <= HIGH_LAST;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: if (cnt == '0) st <= SQ_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  logic active;
  assign active = (st != SQ_IDLE);
  assign cle    = active && (kind == ACC_CMD);
  assign ale    = active && (kind == ACC_ADR);
  assign oe     = active && is_wcycle(kind);
  assign we_n   = !((st == SQ_LOW) && is_wcycle(kind));
  assign re_n   = !((st == SQ_LOW) && (kind == ACC_DRD));
  assign io_out = dbyte_q;
  assign cap_en = (st == SQ_LOW) && (cnt == '0) && (kind == ACC_DRD);
  assign done   = (st == SQ_HIGH) && (cnt == '0);
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 32,
  parameter int NUM_DIE = 16,
  parameter int T_LOW   = 3,
  parameter int T_HIGH  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_ack,
  output logic               nf_cle,
  output logic               nf_ale,
  output logic               nf_we_n,
  output logic               nf_re_n,
  output logic [NUM_DIE-1:0] nf_ce_n,
  output logic [7:0]         nf_io_out,
  output logic               nf_io_oe,
  input  logic [7:0]         nf_io_in,
  input  logic [NUM_DIE-1:0] nf_rb
);
  logic               pending;
  logic               accept;
  acc_e               acc;
  logic               seq_start;
  logic               seq_cap;
  logic               seq_done;
  logic [NUM_DIE-1:0] rb_sync;
  logic [DATA_W-1:0]  die_sel;

  assign acc       = classify(32'(host_addr), host_wr, host_rd);
  assign accept    = host_sel && (host_wr || host_rd) && !pending && !host_ack;
  assign seq_start = accept && is_nand(acc);

  nbb_rb_sync #(.WIDTH(NUM_DIE)) i_rb_sync (
    .clk(clk), .rst_n(rst_n), .async_in(nf_rb), .sync_out(rb_sync)
  );

  nbb_ce_decode #(.NUM_DIE(NUM_DIE), .DATA_W(DATA_W)) i_ce_decode (
    .sel_word(die_sel), .ce_n(nf_ce_n)
  );

  nbb_strobe_seq #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .kind_in(acc),
    .dbyte_in(host_wdata[7:0]), .cle(nf_cle), .ale(nf_ale),
    .we_n(nf_we_n), .re_n(nf_re_n), .oe(nf_io_oe), .io_out(nf_io_out),
    .cap_en(seq_cap), .done(seq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      host_ack   <= 1'b0;
      die_sel    <= '1;
      host_rdata <= '0;
    end else begin
      host_ack <= (accept && !is_nand(acc)) || seq_done;
      if (accept)        pending <= 1'b1;
      else if (host_ack) pending <= 1'b0;
      if (accept && acc == ACC_DIESEL) die_sel <= host_wdata;
      if (accept && acc == ACC_STATUS)
        host_rdata <= DATA_W'(rb_sync);
      else if (accept && acc == ACC_NONE && host_rd)
        host_rdata <= '0;
      else if (seq_cap)
        host_rdata <= DATA_W'(nf_io_in);
    end
  end
endmodule

// File: rtl/nbb_checker.sv
module nbb_checker #(
  parameter int NUM_DIE = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_ack,
  input logic               nf_cle,
  input logic               nf_ale,
  input logic               nf_we_n,
  input logic               nf_re_n,
  input logic               nf_io_oe,
  input logic [NUM_DIE-1:0] nf_ce_n
);
  AST_ONE_DIE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~nf_ce_n) <= 1); // R1
  AST_CLE_ALE_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale)); // R4
  AST_WE_FALL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_we_n) |-> $past(nf_io_oe) && $stable(nf_cle) && $stable(nf_ale)); // R7
  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> nf_io_oe && $stable(nf_cle) && $stable(nf_ale)); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack); // R8
  AST_NO_ACK_MID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !host_ack); // R8
  AST_OE_OFF_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_io_oe); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n)); // R10
endmodule

bind nand_bus_bridge nbb_checker #(.NUM_DIE(NUM_DIE)) i_nbb_checker (
  .clk(clk), .rst_n(rst_n), .host_ack(host_ack), .nf_cle(nf_cle),
  .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
  .nf_io_oe(nf_io_oe), .nf_ce_n(nf_ce_n)
);

// File: tb/test_nand_bus_bridge.sv
module test_nand_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int T_LOW  = 3;
  localparam int T_HIGH = 2;
  localparam int NAND_LAT = 2 + T_LOW + T_HIGH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [27:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ack;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic [15:0] nf_ce_n;
  logic [7:0]  nf_io_out, nf_io_in;
  logic [15:0] nf_rb = 16'h0000;
  logic [7:0]  model_byte = 8'h00;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign nf_io_in = nf_re_n ? 8'h00 : model_byte;

  nand_bus_bridge #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) i_nand_bus_bridge (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ack(host_ack), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_ce_n(nf_ce_n),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb(nf_rb)
  );

  typedef struct packed { logic cle; logic ale; logic rd; logic [7:0] d; } ev_t;
  ev_t sbq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: measures each strobe pulse and compares it to the queue head
  int   run_len = 0;
  ev_t  cur;
  bit   cur_ok;
  logic prev_oe = 0, prev_cle = 0, prev_ale = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nf_we_n || !nf_re_n) begin
        if (run_len == 0) begin
          cur.cle = nf_cle; cur.ale = nf_ale; cur.rd = !nf_re_n;
          cur.d   = nf_re_n ? nf_io_out : 8'h00;
          cur_ok  = nf_re_n ? (prev_oe && nf_io_oe && prev_cle == nf_cle && prev_ale == nf_ale)
                            : (!nf_io_oe && !nf_cle && !nf_ale);
        end else if (nf_cle != cur.cle || nf_ale != cur.ale || (!nf_re_n) != cur.rd ||
                     (!cur.rd && nf_io_out != cur.d)) begin
          cur_ok = 0;
        end
        if (!nf_we_n && !nf_re_n) cur_ok = 0;
        run_len++;
      end else if (run_len != 0) begin
        if (sbq.size() == 0) begin
          chk(0, "R8 unexpected strobe", {20'h0, cur}, 32'h0);
        end else begin
          ev_t e;
          string req;
          e = sbq.pop_front();
          req = e.rd ? "R6/R10" : e.cle ? "R4/R7" : e.ale ? "R5/R7" : "R3/R7";
          chk(cur_ok && cur == e && run_len == T_LOW, req,
              {12'h0, 8'(run_len), cur}, {12'h0, 8'(T_LOW), e});
        end
        run_len = 0;
      end
      prev_oe = nf_io_oe; prev_cle = nf_cle; prev_ale = nf_ale;
    end
  end

  task automatic host_xfer(input bit wr, input logic [27:0] a, input logic [31:0] d,
                           output logic [31:0] rdv, output int lat);
    @(negedge clk);
    host_sel = 1; host_wr = wr; host_rd = !wr; host_addr = a; host_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!host_ack && lat < 200);
    rdv = host_rdata;
    host_sel = 0; host_wr = 0; host_rd = 0;
  endtask

  task automatic nand_write(input logic [27:0] ofs, input logic [7:0] b, input string req);
    logic [31:0] rdv; int lat; ev_t e;
    e.cle = (ofs == 28'h1); e.ale = (ofs == 28'h2); e.rd = 0; e.d = b;
    sbq.push_back(e);
    host_xfer(1, ofs, {24'hABCDE0, b}, rdv, lat);
    chk(lat == NAND_LAT, {req, " R8 ack latency"}, lat, NAND_LAT);
  endtask

  task automatic nand_read(input logic [7:0] exp, input string req);
    logic [31:0] rdv; int lat; ev_t e;
    e = '{cle: 0, ale: 0, rd: 1, d: 8'h00};
    sbq.push_back(e);
    host_xfer(0, 28'h0, 32'h0, rdv, lat);
    chk(lat == NAND_LAT, "R8 read ack latency", lat, NAND_LAT);
    chk(rdv == {24'h0, exp}, req, rdv, {24'h0, exp});
  endtask

  task automatic reg_write(input logic [27:0] a, input logic [31:0] d);
    logic [31:0] rdv; int lat;
    host_xfer(1, a, d, rdv, lat);
    chk(lat == 1, "R8 register ack", lat, 1);
  endtask

  task automatic reg_read(input logic [27:0] a, output logic [31:0] rdv);
    int lat;
    host_xfer(0, a, 32'h0, rdv, lat);
    chk(lat == 1, "R8 register ack", lat, 1);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // reset state
    chk(nf_ce_n == 16'hFFFF, "R1 reset enables", nf_ce_n, 16'hFFFF);
    chk(nf_we_n && nf_re_n && !nf_io_oe, "R9 reset strobes idle",
        {nf_we_n, nf_re_n, nf_io_oe}, 3'b110);
    chk(!host_ack, "R8 no ack at reset", host_ack, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    reg_write(28'hFFFFFFC, 32'd5);
    chk(nf_ce_n == ~(16'h1 << 5), "R1 die 5", nf_ce_n, ~(16'h1 << 5));

    nand_write(28'h1, 8'h70, "R4");
    nand_write(28'h2, 8'h12, "R5");
    nand_write(28'h0, 8'hA5, "R3");
    nand_write(28'h0, 8'h3C, "R3");
    chk(!nf_io_oe, "R9 oe off after write", nf_io_oe, 0);

    model_byte = 8'h5A;
    nand_read(8'h5A, "R6 read byte");

    nf_rb = 16'hA5C3;
    repeat (3) @(negedge clk);
    reg_read(28'hFFFFFF8, rv);
    chk(rv == 32'h0000A5C3, "R2 status", rv, 32'h0000A5C3);

    // ready/busy change lands while a read strobe is capturing data
    model_byte = 8'hC7;
    fork
      nand_read(8'hC7, "R6 read during busy change");
      begin repeat (4) @(negedge clk); nf_rb = 16'h0F0F; end
    join
    reg_read(28'hFFFFFF8, rv);
    chk(rv == 32'h00000F0F, "R2 status after change", rv, 32'h00000F0F);

    reg_write(28'hFFFFFF8, 32'd3);
    chk(nf_ce_n == ~(16'h1 << 5), "R1 status write leaves enables", nf_ce_n, ~(16'h1 << 5));
    reg_write(28'hFFFFFFC, 32'd15);
    chk(nf_ce_n == 16'h7FFF, "R1 die 15", nf_ce_n, 16'h7FFF);
    reg_write(28'hFFFFFFC, 32'd16);
    chk(nf_ce_n == 16'hFFFF, "R1 value 16", nf_ce_n, 16'hFFFF);
    reg_write(28'hFFFFFFC, 32'h0001_0002);
    chk(nf_ce_n == 16'hFFFF, "R1 large value", nf_ce_n, 16'hFFFF);

    reg_write(28'h0000010, 32'h55);
    reg_read(28'h0000020, rv);
    chk(rv == 32'h0, "R8 unmapped read zero", rv, 32'h0);

    reg_write(28'hFFFFFFC, 32'd0);
    nand_write(28'h1, 8'hFF, "R4");
    chk(nf_ce_n == 16'hFFFE, "R1 die 0", nf_ce_n, 16'hFFFE);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R10 every queued strobe seen", sbq.size(), 0);
    chk(!nf_io_oe && nf_we_n && nf_re_n, "R9 idle at end",
        {nf_io_oe, nf_we_n, nf_re_n}, 3'b011);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule